// File: doc/BRIEF.md
# RGB Matrix Panel Row Shifter

This block drives one row transfer into a memoryless, multiplexed RGB LED panel whose upper and lower halves each take their own three-bit colour stream while sharing the clock, latch, output-enable and row-address lines. A start strobe launches a transfer for one row pair and one bit plane. Over 64 consecutive cycles the block asks for pixel column 0 through 63 on a combinational request/response port, picks bit `plane` out of each 8-bit red, green and blue component of the upper pixel (row y) and the lower pixel (row y+16), and presents them on the panel pins with a one-cycle shift strobe.

Alongside the data it generates the panel control signals. The latch rises on the last data cycle. The active-low output enable is blanked on the first and last cycle and beyond a brightness column count. For planes from 1 up to a configurable transition plane that count is divided by a power of two. The row address shows the previous row while plane 0 shifts, because that row's most significant data is still lit. A done strobe follows the latch by one cycle. A higher-level sequencer owns frame storage and the order in which planes are sent.

Top module: `rgb_row_shifter`

## Requirements
- R1: After an accepted start, `shift_o` is high for exactly 64 consecutive cycles, beginning one cycle after the start edge, and `pix_col_o` requests columns 0 to 63 in order while `pix_req_o` is high.
- R2: On the strobe for column k, `rgb_hi_o` equals {R[p], G[p], B[p]} of the upper pixel word for column k and `rgb_lo_o` the same for the lower word. A pixel word is {R[23:16], G[15:8], B[7:0]}, p is the plane index, and bit 2 of each output is red.
- R3: `latch_o` is high only on the 64th shift strobe of a transfer.
- R4: `oe_n_o` is high (dark) on the first and on the last shift strobe of every transfer.
- R5: For plane 0 and for any plane above the transition plane, `oe_n_o` is high on every strobe whose column index is at least the brightness value (1 to 64).
- R6: For a plane j with 1 <= j <= transition plane, the blanking column is brightness >> (transition - j + 1). Below it (and outside the first and last strobe) `oe_n_o` is low.
- R7: During a transfer `addr_o` equals the row index, except for plane 0, where it equals the row index minus one modulo 16. It holds its value between transfers.
- R8: `done_o` is a single-cycle pulse in the cycle after the latch strobe.
- R9: A start seen while a transfer is in progress is ignored. The running transfer keeps its row, plane and column sequence, and no extra transfer follows.
- R10: While reset is high, `shift_o`, `latch_o`, `done_o`, `pix_req_o`, both colour outputs and `addr_o` are zero and `oe_n_o` is high.
- R11: While no transfer is running, `shift_o` is low and `oe_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launches a transfer when idle |
| row_i | input | 4 | Row-pair index (upper row) |
| plane_i | input | 3 | Bit-plane index |
| bright_i | input | 7 | Brightness column count, 1 to 64 |
| split_i | input | 3 | Transition plane for fractional brightness |
| pix_req_o | output | 1 | Pixel request valid |
| pix_col_o | output | 6 | Requested column |
| pix_hi_i | input | 24 | Upper-half pixel word, same cycle |
| pix_lo_i | input | 24 | Lower-half pixel word, same cycle |
| rgb_hi_o | output | 3 | Upper-half colour bits {R,G,B} |
| rgb_lo_o | output | 3 | Lower-half colour bits {R,G,B} |
| shift_o | output | 1 | Panel data clock strobe |
| latch_o | output | 1 | Panel latch |
| oe_n_o | output | 1 | Panel output enable, active low |
| addr_o | output | 4 | Panel row address |
| done_o | output | 1 | Transfer complete pulse |

## Verification
On every cycle the assertions check the relations between the control pins: a latch always comes with a strobe and a dark panel, done only follows a latch, the address does not move inside a transfer, the column counter advances by one while busy whatever the start input does, and the panel is dark whenever no data is shifting. Only the bench scenarios can show the values these pins carry: the colour bit picked for each plane, the exact blanking column for each brightness and transition setting, the previous-row address for plane 0 including the wrap from row 0 to 15, and the fact that a mid-transfer start produces no second transfer.

// File: rtl/rgb_row_pkg.sv
package rgb_row_pkg;
    localparam int COLS     = 64;
    localparam int ROW_W    = 4;
    localparam int PLANE_W  = 3;
    localparam int COMP_W   = 8;
    localparam int BRIGHT_W = 7;
    localparam int COL_W    = $clog2(COLS);
    localparam int PIX_W    = 3 * COMP_W;

    typedef struct packed {
        logic [ROW_W-1:0]    row;
        logic [PLANE_W-1:0]  plane;
        logic [BRIGHT_W-1:0] bright;
        logic [PLANE_W-1:0]  split;
    } job_t;

    // Column from which the panel is kept dark for this job.
    function automatic logic [BRIGHT_W-1:0] blank_from(job_t j);
        logic [PLANE_W:0] sh;
        if (j.plane != '0 && j.plane <= j.split) begin
            sh = {1'b0, j.split} - {1'b0, j.plane} + 1'b1;
            return j.bright >> sh;
        end
        return j.bright;
    endfunction
endpackage

// File: rtl/rgb_row_seq.sv
module rgb_row_seq
    import rgb_row_pkg::*;
#(
    parameter int NCOL = COLS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  job_t                     job_i,
    output logic                     busy_o,
    output logic [$clog2(NCOL)-1:0]  col_o,
    output job_t                     job_o
);
    localparam int CW = $clog2(NCOL);
    localparam logic [CW-1:0] LAST = CW'(NCOL - 1);

    logic          busy_q;
    logic [CW-1:0] col_q;
    job_t          job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            col_q  <= '0;
            job_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                col_q  <= '0;
                job_q  <= job_i;
            end
        end else if (col_q == LAST) begin
            busy_q <= 1'b0;
        end else begin
            col_q <= col_q + 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign col_o  = col_q;
    assign job_o  = job_q;

    // R9: a start during a transfer neither restarts the column nor changes the job
    a_r9_col_advances: assert property (@(posedge clk) disable iff (rst)
        (busy_q && col_q != LAST) |=> (busy_q && col_q == $past(col_q) + 1'b1));
    a_r9_job_held: assert property (@(posedge clk) disable iff (rst)
        (busy_q && col_q != LAST) |=> $stable(job_q));
endmodule

// File: rtl/rgb_row_blank.sv
module rgb_row_blank
    import rgb_row_pkg::*;
#(
    parameter int NCOL = COLS
) (
    input  job_t                     job_i,
    input  logic [$clog2(NCOL)-1:0]  col_i,
    output logic                     dark_o
);
    localparam int CW = $clog2(NCOL);
    logic [BRIGHT_W-1:0] edge_col;
    logic                at_end;

    always_comb begin
        edge_col = blank_from(job_i);
        at_end   = (col_i == '0) || (col_i == CW'(NCOL - 1));
        dark_o   = at_end || (BRIGHT_W'(col_i) >= edge_col);
    end
endmodule

// File: rtl/rgb_row_bits.sv
module rgb_row_bits
    import rgb_row_pkg::*;
#(
    parameter int CW = COMP_W
) (
    input  logic [3*CW-1:0]        pix_i,
    input  logic [PLANE_W-1:0]     plane_i,
    output logic [2:0]             rgb_o
);
    for (genvar c = 0; c < 3; c++) begin : g_comp
        logic [CW-1:0] comp;
        assign comp     = pix_i[c*CW +: CW];
        assign rgb_o[c] = comp[plane_i];
    end
endmodule

// File: rtl/rgb_row_shifter.sv
module rgb_row_shifter
    import rgb_row_pkg::*;
#(
    parameter int NCOL = COLS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [ROW_W-1:0]       row_i,
    input  logic [PLANE_W-1:0]     plane_i,
    input  logic [BRIGHT_W-1:0]    bright_i,
    input  logic [PLANE_W-1:0]     split_i,
    output logic                   pix_req_o,
    output logic [$clog2(NCOL)-1:0] pix_col_o,
    input  logic [PIX_W-1:0]       pix_hi_i,
    input  logic [PIX_W-1:0]       pix_lo_i,
    output logic [2:0]             rgb_hi_o,
    output logic [2:0]             rgb_lo_o,
    output logic                   shift_o,
    output logic                   latch_o,
    output logic                   oe_n_o,
    output logic [ROW_W-1:0]       addr_o,
    output logic                   done_o
);
    localparam int CW = $clog2(NCOL);

    job_t          job_in, job;
    logic          busy, dark;
    logic [CW-1:0] col;
    logic [2:0]    bits_hi, bits_lo;

    assign job_in = '{row: row_i, plane: plane_i, bright: bright_i, split: split_i};

    rgb_row_seq #(.NCOL(NCOL)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .job_i(job_in),
        .busy_o(busy), .col_o(col), .job_o(job)
    );

    rgb_row_blank #(.NCOL(NCOL)) u_blank (
        .job_i(job), .col_i(col), .dark_o(dark)
    );

    rgb_row_bits #(.CW(COMP_W)) u_bits_hi (
        .pix_i(pix_hi_i), .plane_i(job.plane), .rgb_o(bits_hi)
    );
    rgb_row_bits #(.CW(COMP_W)) u_bits_lo (
        .pix_i(pix_lo_i), .plane_i(job.plane), .rgb_o(bits_lo)
    );

    assign pix_req_o = busy;
    assign pix_col_o = col;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_o  <= 1'b0;
            latch_o  <= 1'b0;
            oe_n_o   <= 1'b1;
            addr_o   <= '0;
            rgb_hi_o <= '0;
            rgb_lo_o <= '0;
            done_o   <= 1'b0;
        end else begin
            shift_o  <= busy;
            latch_o  <= busy && (col == CW'(NCOL - 1));
            oe_n_o   <= busy ? dark : 1'b1;
            rgb_hi_o <= busy ? bits_hi : 3'b000;
            rgb_lo_o <= busy ? bits_lo : 3'b000;
            done_o   <= latch_o;
            if (busy)
                addr_o <= (job.plane == '0) ? job.row - 1'b1 : job.row;
        end
    end

    // R3/R4: the latch cycle is a data strobe with the panel dark
    a_r3_latch_dark: assert property (@(posedge clk) disable iff (rst)
        latch_o |-> (shift_o && oe_n_o));
    // R8: done follows a latch and nothing else
    a_r8_done_after_latch: assert property (@(posedge clk) disable iff (rst)
        latch_o |=> done_o);
    a_r8_done_source: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(latch_o));
    // R7: address steady inside a transfer
    a_r7_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (shift_o && $past(shift_o)) |-> $stable(addr_o));
    // R11: dark whenever nothing shifts
    a_r11_idle_dark: assert property (@(posedge clk) disable iff (rst)
        !shift_o |-> oe_n_o);
    // R4: first strobe of a transfer is dark
    a_r4_first_dark: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_o) |-> oe_n_o);
endmodule

// File: tb/rgb_row_shifter_bench.sv
module rgb_row_shifter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  row_i = '0;
    logic [2:0]  plane_i = '0;
    logic [6:0]  bright_i = 7'd64;
    logic [2:0]  split_i = '0;
    logic        pix_req_o;
    logic [5:0]  pix_col_o;
    logic [23:0] pix_hi_i, pix_lo_i;
    logic [2:0]  rgb_hi_o, rgb_lo_o;
    logic        shift_o, latch_o, oe_n_o, done_o;
    logic [3:0]  addr_o;

    int errors = 0;
    int checks = 0;
    int cur_row = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgb_row_shifter u_rgb_row_shifter (
        .clk(clk), .rst(rst), .start_i(start_i), .row_i(row_i), .plane_i(plane_i),
        .bright_i(bright_i), .split_i(split_i), .pix_req_o(pix_req_o),
        .pix_col_o(pix_col_o), .pix_hi_i(pix_hi_i), .pix_lo_i(pix_lo_i),
        .rgb_hi_o(rgb_hi_o), .rgb_lo_o(rgb_lo_o), .shift_o(shift_o),
        .latch_o(latch_o), .oe_n_o(oe_n_o), .addr_o(addr_o), .done_o(done_o)
    );

    function automatic logic [23:0] pixel(int col, int y);
        logic [7:0] r, g, b;
        r = 8'((col * 5 + y * 3) % 256);
        g = 8'(col ^ (y * 7));
        b = ~8'(col + y);
        return {r, g, b};
    endfunction

    function automatic logic [2:0] bits_of(logic [23:0] p, int pl);
        return {p[16 + pl], p[8 + pl], p[pl]};
    endfunction

    assign pix_hi_i = pixel(int'(pix_col_o), cur_row);
    assign pix_lo_i = pixel(int'(pix_col_o), cur_row + 16);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {row, plane, bright, split, expected addr, expected blanking column}
    localparam logic [27:0] VECS [0:7] = '{
        {4'd5,  3'd0, 7'd64, 3'd1, 4'd4,  7'd64},
        {4'd0,  3'd0, 7'd28, 3'd1, 4'd15, 7'd28},
        {4'd7,  3'd1, 7'd28, 3'd1, 4'd7,  7'd14},
        {4'd9,  3'd3, 7'd40, 3'd3, 4'd9,  7'd20},
        {4'd9,  3'd1, 7'd40, 3'd3, 4'd9,  7'd5},
        {4'd15, 3'd7, 7'd10, 3'd3, 4'd15, 7'd10},
        {4'd3,  3'd2, 7'd64, 3'd0, 4'd3,  7'd64},
        {4'd12, 3'd2, 7'd1,  3'd2, 4'd12, 7'd0}
    };

    task automatic run(input logic [27:0] v, input bit inject);
        int pl, ea, ec;
        int n_shift, n_rgb, n_lat, n_oe, n_addr, n_done, bad_oe_k;
        n_shift = 0; n_rgb = 0; n_lat = 0; n_oe = 0; n_addr = 0; n_done = 0; bad_oe_k = -1;
        cur_row  = int'(v[27:24]);
        pl       = int'(v[23:21]);
        ea       = int'(v[10:7]);
        ec       = int'(v[6:0]);
        row_i    = v[27:24];
        plane_i  = v[23:21];
        bright_i = v[20:14];
        split_i  = v[13:11];
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (inject && k == 10) begin
                start_i = 1'b1; row_i = 4'd2; plane_i = 3'd0;
            end
            if (inject && k == 11) begin
                start_i = 1'b0; row_i = v[27:24]; plane_i = v[23:21];
            end
            if (!shift_o) n_shift++;
            if (rgb_hi_o != bits_of(pixel(k, cur_row), pl) ||
                rgb_lo_o != bits_of(pixel(k, cur_row + 16), pl)) n_rgb++;
            if (latch_o != (k == 63)) n_lat++;
            if (oe_n_o != (k == 0 || k == 63 || k >= ec)) begin
                n_oe++; bad_oe_k = k;
            end
            if (int'(addr_o) != ea) n_addr++;
            if (done_o) n_done++;
        end
        check(n_shift == 0, "R1 strobes", n_shift, 0);
        check(n_rgb == 0, "R2 colour bits", n_rgb, 0);
        check(n_lat == 0, "R3 latch position", n_lat, 0);
        check(n_oe == 0, (pl != 0 && pl <= int'(v[13:11])) ? "R6 fractional blanking" : "R4/R5 blanking",
              bad_oe_k, ec);
        check(n_addr == 0, "R7 address", int'(addr_o), ea);
        @(negedge clk);
        check(done_o && !shift_o && n_done == 0, "R8 done after latch", int'(done_o), 1);
        @(negedge clk);
        check(!done_o && !shift_o && oe_n_o, "R11 idle after done", int'(shift_o), 0);
        check(int'(addr_o) == ea, "R7 address held", int'(addr_o), ea);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!shift_o && !latch_o && !done_o && !pix_req_o && oe_n_o &&
              addr_o == 0 && rgb_hi_o == 0 && rgb_lo_o == 0,
              "R10 reset state", int'(oe_n_o), 1);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!shift_o && oe_n_o, "R11 idle before start", int'(shift_o), 0);

        for (int i = 0; i < 8; i++) run(VECS[i], 1'b0);

        // R9: start pulsed at column 10 of a running transfer
        run({4'd6, 3'd4, 7'd64, 3'd1, 4'd6, 7'd64}, 1'b1);
        repeat (3) @(negedge clk);
        check(!shift_o && !pix_req_o, "R9 no extra transfer", int'(shift_o), 0);

        // R10: reset in the middle of a transfer
        row_i = 4'd4; plane_i = 3'd1; bright_i = 7'd64; split_i = 3'd0;
        cur_row = 4;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!shift_o && !latch_o && oe_n_o && addr_o == 0 && !pix_req_o,
              "R10 reset mid transfer", int'(shift_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!shift_o && oe_n_o, "R11 idle after reset", int'(shift_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule